// File: doc/BRIEF.md
# Tagged Operand Matching Firing Unit

This block is the instruction store at the heart of a tag-driven dataflow node. Instructions are loaded into a small pool of entries. Each entry has an opcode, a destination tag and two operand slots. A slot names its operand by a dependency tag, or it is filled with a literal when the instruction is loaded. The store does not order instructions by program position or by address. Every returning result token is compared against all waiting slots at the same time, and each slot whose tag matches takes the value.

An entry whose two slots are both filled is ready. A round-robin arbiter offers one ready entry per cycle on the instruction-token output, as a single word that carries the opcode, the destination tag and both operand values. The entry is released when the execution side accepts the token. A result token that no waiting slot wants is discarded, and a one-cycle flag reports the discard. Back-pressure on the load and result inputs keeps every accepted token from being lost.

Top module: `tag_match_fire_unit`

## Requirements
- R1: After reset the store is empty: `it_valid` is 0, `ld_ready` is 1, `dt_ready` is 1 and `unmatched` is 0.
- R2: A load is taken on a clock edge where `ld_valid` and `ld_ready` are both 1, and it goes into a free entry. A slot whose literal flag is 1 is filled at once. An instruction with two literal operands is offered on the token output in the first cycle after its load edge.
- R3: A data token taken on an edge fills every valid, still-empty slot whose tag equals `dt_tag`, in all entries, on that same edge. The slot takes `dt_value`.
- R4: An entry is not offered until both of its slots are filled. Filling only one slot leaves `it_valid` at 0.
- R5: An instruction token presents the opcode, the destination tag, the value of slot A on `it_a_value` and the value of slot B on `it_b_value`, all from the same entry.
- R6: Instructions leave in the order their operands become available, whatever order they were loaded in.
- R7: Arbitration is round robin over the entry index. After entry i is issued, the search for the next token starts at entry i+1 and wraps past the last entry. At most one token leaves per cycle.
- R8: While `it_valid` is 1 and `it_ready` is 0, the offered token and its contents stay unchanged. An entry is freed on the edge where `it_valid` and `it_ready` are both 1.
- R9: A data token that is taken and matches no waiting slot is dropped. `unmatched` is 1 during the cycle after the edge that took it, and 0 in the cycle after that if no further token arrives.
- R10: With all 16 entries occupied, `ld_ready` is 0 and a presented load leaves the store unchanged.
- R11: When a load is being taken whose non-literal slot tag equals `dt_tag`, `dt_ready` is 0. The data token is taken on a later edge, and the newly loaded slot then captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Load request |
| ld_ready | output | 1 | A free entry exists |
| ld_opcode | input | 8 | Opcode of the loaded instruction |
| ld_dest_tag | input | 8 | Tag its result will carry |
| ld_a_tag | input | 8 | Dependency tag of slot A |
| ld_a_lit | input | 1 | Slot A is a literal |
| ld_a_value | input | 16 | Literal value of slot A |
| ld_b_tag | input | 8 | Dependency tag of slot B |
| ld_b_lit | input | 1 | Slot B is a literal |
| ld_b_value | input | 16 | Literal value of slot B |
| dt_valid | input | 1 | Result token present |
| dt_ready | output | 1 | Result token can be taken |
| dt_tag | input | 8 | Tag of the result |
| dt_value | input | 16 | Value of the result |
| it_valid | output | 1 | Instruction token offered |
| it_ready | input | 1 | Execution side accepts the token |
| it_opcode | output | 8 | Token opcode |
| it_dest_tag | output | 8 | Token destination tag |
| it_a_value | output | 16 | Token slot A value |
| it_b_value | output | 16 | Token slot B value |
| unmatched | output | 1 | One-cycle flag for a dropped result token |

## Verification
A present bit that is set too early makes an instruction fire with a stale operand. The bad value shows on the token output in the first cycle after the load or capture edge. A present bit that is lost leaves an instruction stuck, so a later drain comes up short by one token. A corrupted round-robin pointer or lock changes which opcode appears next, or changes it during a stall, and this shows on the first handshake after the fault. An entry that is never released, or released twice, shows up as a wrong `ld_ready` once the store is filled to capacity.

// File: rtl/tmf_pkg.sv
package tmf_pkg;

  localparam int unsigned TMF_ENTRIES = 16;
  localparam int unsigned TMF_OP_W    = 8;
  localparam int unsigned TMF_TAG_W   = 8;
  localparam int unsigned TMF_VAL_W   = 16;
  localparam int unsigned TMF_SLOTS   = 2;

  // Modular index step used by the round-robin search.
  function automatic int unsigned tmf_wrap(input int unsigned base,
                                           input int unsigned off,
                                           input int unsigned n);
    int unsigned s;
    s = base + off;
    while (s >= n) s = s - n;
    return s;
  endfunction

endpackage

// File: rtl/tmf_entry.sv
module tmf_entry
  import tmf_pkg::*;
#(
  parameter int unsigned OP_W  = TMF_OP_W,
  parameter int unsigned TAG_W = TMF_TAG_W,
  parameter int unsigned VAL_W = TMF_VAL_W,
  localparam int unsigned NS   = TMF_SLOTS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_en,
  input  logic [OP_W-1:0]           ld_opcode,
  input  logic [TAG_W-1:0]          ld_dest,
  input  logic [NS-1:0][TAG_W-1:0]  ld_tag,
  input  logic [NS-1:0]             ld_lit,
  input  logic [NS-1:0][VAL_W-1:0]  ld_val,
  input  logic                      dt_en,
  input  logic [TAG_W-1:0]          dt_tag,
  input  logic [VAL_W-1:0]          dt_val,
  input  logic                      free_en,
  output logic                      valid_o,
  output logic                      ready_o,
  output logic                      hit_o,
  output logic [OP_W-1:0]           opcode_o,
  output logic [TAG_W-1:0]          dest_o,
  output logic [NS-1:0][VAL_W-1:0]  val_o
);

  logic              valid_q, valid_d;
  logic [OP_W-1:0]   opcode_q;
  logic [TAG_W-1:0]  dest_q;
  logic [NS-1:0]     present_q, present_d;
  logic [NS-1:0]     waiting;
  logic [NS-1:0]     capture;

  // Entry-level occupancy
  always_comb begin
    valid_d = valid_q;
    if (ld_en)        valid_d = 1'b1;
    else if (free_en) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  // Instruction fields: no reset, written only on load
  always_ff @(posedge clk) begin
    if (ld_en) begin
      opcode_q <= ld_opcode;
      dest_q   <= ld_dest;
    end
  end

  // Per-slot tag match and capture
  for (genvar s = 0; s < NS; s++) begin : g_slot
    logic [TAG_W-1:0] tag_q;
    logic [VAL_W-1:0] val_q, val_d;
    logic             val_en;

    assign waiting[s] = valid_q && !present_q[s] && (tag_q == dt_tag);
    assign capture[s] = dt_en && waiting[s];

    always_comb begin
      present_d[s] = present_q[s];
      val_d        = val_q;
      val_en       = 1'b0;
      if (ld_en) begin
        present_d[s] = ld_lit[s];
        val_d        = ld_val[s];
        val_en       = 1'b1;
      end else if (capture[s]) begin
        present_d[s] = 1'b1;
        val_d        = dt_val;
        val_en       = 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (ld_en)  tag_q <= ld_tag[s];
      if (val_en) val_q <= val_d;
    end

    assign val_o[s] = val_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) present_q <= '0;
    else        present_q <= present_d;
  end

  assign valid_o  = valid_q;
  assign ready_o  = valid_q && (&present_q);
  assign hit_o    = |waiting;
  assign opcode_o = opcode_q;
  assign dest_o   = dest_q;

endmodule

// File: rtl/tmf_free_pick.sv
module tmf_free_pick #(
  parameter int unsigned N = 16
) (
  input  logic [N-1:0] occupied,
  output logic         free_any,
  output logic [N-1:0] free_onehot
);

  always_comb begin
    free_any    = 1'b0;
    free_onehot = '0;
    for (int i = 0; i < N; i++) begin
      if (!free_any && !occupied[i]) begin
        free_any       = 1'b1;
        free_onehot[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/tmf_rr_arb.sv
module tmf_rr_arb
  import tmf_pkg::*;
#(
  parameter int unsigned N  = 16,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          advance,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] grant_idx,
  output logic          any
);

  logic [IW-1:0] ptr_q, ptr_d;
  logic [IW-1:0] lock_idx_q, lock_idx_d;
  logic          lock_q, lock_d;
  logic [IW-1:0] pick_idx;
  logic          pick_found;

  // Search from the pointer, wrapping
  always_comb begin
    pick_found = 1'b0;
    pick_idx   = '0;
    for (int unsigned k = 0; k < N; k++) begin
      if (!pick_found && req[tmf_wrap(32'(ptr_q), k, N)]) begin
        pick_found = 1'b1;
        pick_idx   = IW'(tmf_wrap(32'(ptr_q), k, N));
      end
    end
  end

  // A stalled offer keeps its index until accepted
  assign grant_idx = lock_q ? lock_idx_q : pick_idx;
  assign any       = lock_q | pick_found;

  for (genvar i = 0; i < N; i++) begin : g_gnt
    assign grant[i] = any && (grant_idx == IW'(i));
  end

  always_comb begin
    lock_d     = any && !advance;
    lock_idx_d = grant_idx;
    ptr_d      = ptr_q;
    if (advance) ptr_d = IW'(tmf_wrap(32'(grant_idx), 1, N));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else begin
      ptr_q      <= ptr_d;
      lock_q     <= lock_d;
      lock_idx_q <= lock_idx_d;
    end
  end

endmodule

// File: rtl/tag_match_fire_unit.sv
module tag_match_fire_unit
  import tmf_pkg::*;
#(
  parameter int unsigned ENTRIES = TMF_ENTRIES,
  parameter int unsigned OP_W    = TMF_OP_W,
  parameter int unsigned TAG_W   = TMF_TAG_W,
  parameter int unsigned VAL_W   = TMF_VAL_W,
  localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  output logic             ld_ready,
  input  logic [OP_W-1:0]  ld_opcode,
  input  logic [TAG_W-1:0] ld_dest_tag,
  input  logic [TAG_W-1:0] ld_a_tag,
  input  logic             ld_a_lit,
  input  logic [VAL_W-1:0] ld_a_value,
  input  logic [TAG_W-1:0] ld_b_tag,
  input  logic             ld_b_lit,
  input  logic [VAL_W-1:0] ld_b_value,
  input  logic             dt_valid,
  output logic             dt_ready,
  input  logic [TAG_W-1:0] dt_tag,
  input  logic [VAL_W-1:0] dt_value,
  output logic             it_valid,
  input  logic             it_ready,
  output logic [OP_W-1:0]  it_opcode,
  output logic [TAG_W-1:0] it_dest_tag,
  output logic [VAL_W-1:0] it_a_value,
  output logic [VAL_W-1:0] it_b_value,
  output logic             unmatched
);

  localparam int unsigned NS = TMF_SLOTS;

  logic [ENTRIES-1:0] entry_valid;
  logic [ENTRIES-1:0] entry_ready;
  logic [ENTRIES-1:0] entry_hit;
  logic [ENTRIES-1:0] free_onehot;
  logic [ENTRIES-1:0] arb_grant;
  logic [IW-1:0]      arb_idx;
  logic               free_any;
  logic               arb_any;

  logic [OP_W-1:0]          e_opcode [ENTRIES];
  logic [TAG_W-1:0]         e_dest   [ENTRIES];
  logic [NS-1:0][VAL_W-1:0] e_val    [ENTRIES];

  logic [NS-1:0][TAG_W-1:0] ld_tag_pk;
  logic [NS-1:0]            ld_lit_pk;
  logic [NS-1:0][VAL_W-1:0] ld_val_pk;

  logic ld_fire, dt_fire, it_fire;
  logic ld_tag_clash;
  logic unmatched_q, unmatched_d;

  assign ld_tag_pk = {ld_b_tag,   ld_a_tag};
  assign ld_lit_pk = {ld_b_lit,   ld_a_lit};
  assign ld_val_pk = {ld_b_value, ld_a_value};

  // Input handshakes: a load wins over a clashing result token
  assign ld_ready     = free_any;
  assign ld_fire      = ld_valid && ld_ready;
  assign ld_tag_clash = (!ld_a_lit && (ld_a_tag == dt_tag)) ||
                        (!ld_b_lit && (ld_b_tag == dt_tag));
  assign dt_ready     = !(ld_fire && ld_tag_clash);
  assign dt_fire      = dt_valid && dt_ready;

  tmf_free_pick #(.N(ENTRIES)) u_free (
    .occupied    (entry_valid),
    .free_any    (free_any),
    .free_onehot (free_onehot)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    tmf_entry #(
      .OP_W  (OP_W),
      .TAG_W (TAG_W),
      .VAL_W (VAL_W)
    ) u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .ld_en     (ld_fire && free_onehot[i]),
      .ld_opcode (ld_opcode),
      .ld_dest   (ld_dest_tag),
      .ld_tag    (ld_tag_pk),
      .ld_lit    (ld_lit_pk),
      .ld_val    (ld_val_pk),
      .dt_en     (dt_fire),
      .dt_tag    (dt_tag),
      .dt_val    (dt_value),
      .free_en   (it_fire && arb_grant[i]),
      .valid_o   (entry_valid[i]),
      .ready_o   (entry_ready[i]),
      .hit_o     (entry_hit[i]),
      .opcode_o  (e_opcode[i]),
      .dest_o    (e_dest[i]),
      .val_o     (e_val[i])
    );
  end

  tmf_rr_arb #(.N(ENTRIES)) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (entry_ready),
    .advance   (it_fire),
    .grant     (arb_grant),
    .grant_idx (arb_idx),
    .any       (arb_any)
  );

  // Instruction token output
  assign it_valid    = arb_any;
  assign it_fire     = it_valid && it_ready;
  assign it_opcode   = e_opcode[arb_idx];
  assign it_dest_tag = e_dest[arb_idx];
  assign it_a_value  = e_val[arb_idx][0];
  assign it_b_value  = e_val[arb_idx][1];

  // Dropped-token flag
  assign unmatched_d = dt_fire && !(|entry_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unmatched_q <= 1'b0;
    else        unmatched_q <= unmatched_d;
  end

  assign unmatched = unmatched_q;

endmodule

// File: rtl/tmf_chk.sv
module tmf_chk #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned OP_W    = 8,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned VAL_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ld_valid,
  input logic               ld_ready,
  input logic               dt_valid,
  input logic               dt_ready,
  input logic               it_valid,
  input logic               it_ready,
  input logic [OP_W-1:0]    it_opcode,
  input logic [TAG_W-1:0]   it_dest_tag,
  input logic [VAL_W-1:0]   it_a_value,
  input logic [VAL_W-1:0]   it_b_value,
  input logic               unmatched,
  input logic [ENTRIES-1:0] occ_vec,
  input logic [ENTRIES-1:0] grant_vec
);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (it_valid && !it_ready) |=> (it_valid && $stable(it_opcode) &&
      $stable(it_dest_tag) && $stable(it_a_value) && $stable(it_b_value)));

  // R8
  issue_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (it_valid && it_ready && !(ld_valid && ld_ready)) |=>
      ($countones(occ_vec) == $past($countones(occ_vec)) - 1));

  // R2
  load_occupy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && ld_ready && !(it_valid && it_ready)) |=>
      ($countones(occ_vec) == $past($countones(occ_vec)) + 1));

  // R9
  drop_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unmatched |-> $past(dt_valid && dt_ready));

  // R10
  full_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&occ_vec) |-> !ld_ready);

  // R11
  dt_backoff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_valid && !dt_ready) |-> (ld_valid && ld_ready));

  // R7
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_vec) && ((grant_vec & ~occ_vec) == '0));

endmodule

bind tag_match_fire_unit tmf_chk #(
  .ENTRIES (ENTRIES),
  .OP_W    (OP_W),
  .TAG_W   (TAG_W),
  .VAL_W   (VAL_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ld_valid    (ld_valid),
  .ld_ready    (ld_ready),
  .dt_valid    (dt_valid),
  .dt_ready    (dt_ready),
  .it_valid    (it_valid),
  .it_ready    (it_ready),
  .it_opcode   (it_opcode),
  .it_dest_tag (it_dest_tag),
  .it_a_value  (it_a_value),
  .it_b_value  (it_b_value),
  .unmatched   (unmatched),
  .occ_vec     (entry_valid),
  .grant_vec   (arb_grant)
);

// File: tb/sim_tag_match_fire_unit.sv
`timescale 1ns/1ps
module sim_tag_match_fire_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_valid = 1'b0, ld_ready;
  logic [7:0]  ld_opcode = '0, ld_dest_tag = '0, ld_a_tag = '0, ld_b_tag = '0;
  logic        ld_a_lit = 1'b0, ld_b_lit = 1'b0;
  logic [15:0] ld_a_value = '0, ld_b_value = '0;
  logic        dt_valid = 1'b0, dt_ready;
  logic [7:0]  dt_tag = '0;
  logic [15:0] dt_value = '0;
  logic        it_valid, it_ready = 1'b0;
  logic [7:0]  it_opcode, it_dest_tag;
  logic [15:0] it_a_value, it_b_value;
  logic        unmatched;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  tag_match_fire_unit u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] op, input logic [7:0] dest,
                      input logic [7:0] at, input logic al, input logic [15:0] av,
                      input logic [7:0] bt, input logic bl, input logic [15:0] bv);
    @(negedge clk);
    ld_opcode = op; ld_dest_tag = dest;
    ld_a_tag = at; ld_a_lit = al; ld_a_value = av;
    ld_b_tag = bt; ld_b_lit = bl; ld_b_value = bv;
    ld_valid = 1'b1;
    #1;
    while (!ld_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic send(input logic [7:0] tag, input logic [15:0] val,
                      input logic exp_drop, input string req);
    @(negedge clk);
    dt_tag = tag; dt_value = val; dt_valid = 1'b1;
    #1;
    while (!dt_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    dt_valid = 1'b0;
    #1;
    chk(unmatched == exp_drop, req, "unmatched after data token", unmatched, exp_drop);
  endtask

  task automatic take(output bit got, output logic [7:0] op, output logic [7:0] dest,
                      output logic [15:0] a, output logic [15:0] b);
    int waited = 0;
    @(negedge clk);
    it_ready = 1'b1;
    #1;
    while (!it_valid && waited < 100) begin @(negedge clk); #1; waited++; end
    got = it_valid; op = it_opcode; dest = it_dest_tag; a = it_a_value; b = it_b_value;
    if (got) @(negedge clk);
    it_ready = 1'b0;
  endtask

  task automatic expect_token(input string req, input logic [7:0] eop,
                              input logic [7:0] edest, input logic [15:0] ea,
                              input logic [15:0] eb);
    bit got; logic [7:0] op, dest; logic [15:0] a, b;
    take(got, op, dest, a, b);
    chk(got, req, "token offered", got, 1);
    chk(op == eop, req, "opcode", op, eop);
    chk(dest == edest, req, "dest tag", dest, edest);
    chk(a == ea, req, "slot A value", a, ea);
    chk(b == eb, req, "slot B value", b, eb);
  endtask

  task automatic t_reset;
    #1;
    chk(it_valid == 0, "R1", "it_valid", it_valid, 0);
    chk(ld_ready == 1, "R1", "ld_ready", ld_ready, 1);
    chk(dt_ready == 1, "R1", "dt_ready", dt_ready, 1);
    chk(unmatched == 0, "R1", "unmatched", unmatched, 0);
  endtask

  // R7 round robin, R2 literal loads, R8 stall hold
  task automatic t_round_robin;
    load(8'h01, 8'hD1, 8'h00, 1, 16'h0A01, 8'h00, 1, 16'h0B01);
    #1;
    chk(it_valid == 1, "R2", "two-literal load offered next cycle", it_valid, 1);
    load(8'h02, 8'hD2, 8'h00, 1, 16'h0A02, 8'h00, 1, 16'h0B02);
    load(8'h03, 8'hD3, 8'h00, 1, 16'h0A03, 8'h00, 1, 16'h0B03);
    #1;
    chk(it_opcode == 8'h01, "R7", "first grant from entry 0", it_opcode, 8'h01);
    repeat (3) @(negedge clk);
    #1;
    chk(it_valid == 1 && it_opcode == 8'h01, "R8", "offer held while stalled", it_opcode, 8'h01);
    expect_token("R5", 8'h01, 8'hD1, 16'h0A01, 16'h0B01);
    load(8'h04, 8'hD4, 8'h00, 1, 16'h0A04, 8'h00, 1, 16'h0B04);
    expect_token("R7", 8'h02, 8'hD2, 16'h0A02, 16'h0B02);
    expect_token("R7", 8'h03, 8'hD3, 16'h0A03, 16'h0B03);
    expect_token("R7", 8'h04, 8'hD4, 16'h0A04, 16'h0B04);
    #1;
    chk(it_valid == 0, "R8", "store drained", it_valid, 0);
  endtask

  task automatic t_wait_both;
    load(8'h21, 8'h31, 8'h10, 0, 16'h0, 8'h11, 0, 16'h0);
    send(8'h10, 16'h1111, 0, "R3");
    repeat (2) @(negedge clk);
    #1;
    chk(it_valid == 0, "R4", "one operand only, no fire", it_valid, 0);
    send(8'h11, 16'h2222, 0, "R3");
    expect_token("R5", 8'h21, 8'h31, 16'h1111, 16'h2222);
  endtask

  task automatic t_multicast;
    bit got; logic [7:0] op, dest; logic [15:0] a, b;
    bit [2:0] seen = '0;
    load(8'h41, 8'h51, 8'h55, 0, 16'h0, 8'h00, 1, 16'h0007);
    load(8'h42, 8'h52, 8'h00, 1, 16'h0009, 8'h55, 0, 16'h0);
    load(8'h43, 8'h53, 8'h55, 0, 16'h0, 8'h55, 0, 16'h0);
    send(8'h55, 16'hABCD, 0, "R3");
    for (int k = 0; k < 3; k++) begin
      take(got, op, dest, a, b);
      chk(got, "R3", "woken token", got, 1);
      case (op)
        8'h41: begin seen[0] = 1; chk(a == 16'hABCD && b == 16'h0007, "R3", "entry 41 values", {a, b}, 32'hABCD0007); end
        8'h42: begin seen[1] = 1; chk(a == 16'h0009 && b == 16'hABCD, "R3", "entry 42 values", {a, b}, 32'h0009ABCD); end
        8'h43: begin seen[2] = 1; chk(a == 16'hABCD && b == 16'hABCD, "R3", "entry 43 values", {a, b}, 32'hABCDABCD); end
        default: chk(0, "R3", "unexpected opcode", op, 8'h41);
      endcase
    end
    chk(seen == 3'b111, "R3", "all three waiters fired", seen, 3'b111);
  endtask

  task automatic t_order;
    load(8'h61, 8'h71, 8'h20, 0, 16'h0, 8'h00, 1, 16'h0001);
    load(8'h62, 8'h72, 8'h21, 0, 16'h0, 8'h00, 1, 16'h0002);
    send(8'h21, 16'h3333, 0, "R6");
    expect_token("R6", 8'h62, 8'h72, 16'h3333, 16'h0002);
    send(8'h20, 16'h4444, 0, "R6");
    expect_token("R6", 8'h61, 8'h71, 16'h4444, 16'h0001);
  endtask

  task automatic t_unmatched;
    send(8'hEE, 16'h5555, 1, "R9");
    @(negedge clk);
    #1;
    chk(unmatched == 0, "R9", "flag lasts one cycle", unmatched, 0);
    chk(it_valid == 0, "R9", "dropped token wakes nothing", it_valid, 0);
  endtask

  task automatic t_full;
    bit got; logic [7:0] op, dest; logic [15:0] a, b;
    bit [15:0] seen = '0;
    int n_tok = 0;
    for (int i = 0; i < 16; i++)
      load(8'h80 + 8'(i), 8'hC0, 8'h77, 0, 16'h0, 8'h00, 1, 16'(i));
    #1;
    chk(ld_ready == 0, "R10", "ld_ready when full", ld_ready, 0);
    @(negedge clk);
    ld_opcode = 8'hFF; ld_a_lit = 1; ld_b_lit = 1; ld_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      #1;
      chk(ld_ready == 0, "R10", "load refused while full", ld_ready, 0);
      @(negedge clk);
    end
    ld_valid = 1'b0;
    send(8'h77, 16'h0055, 0, "R3");
    for (int k = 0; k < 16; k++) begin
      take(got, op, dest, a, b);
      if (got && op >= 8'h80 && op <= 8'h8F && b == 16'(op - 8'h80) && a == 16'h0055) begin
        seen[op - 8'h80] = 1'b1;
        n_tok++;
      end
    end
    chk(n_tok == 16 && seen == 16'hFFFF, "R10", "all 16 entries issued", n_tok, 16);
    #1;
    chk(it_valid == 0, "R10", "refused load never entered", it_valid, 0);
    chk(ld_ready == 1, "R10", "ld_ready after drain", ld_ready, 1);
  endtask

  task automatic t_clash;
    @(negedge clk);
    ld_opcode = 8'h90; ld_dest_tag = 8'hA0;
    ld_a_tag = 8'h33; ld_a_lit = 0; ld_b_lit = 1; ld_b_value = 16'h0005;
    ld_valid = 1'b1;
    dt_tag = 8'h33; dt_value = 16'h4444; dt_valid = 1'b1;
    #1;
    chk(ld_ready == 1, "R11", "load taken first", ld_ready, 1);
    chk(dt_ready == 0, "R11", "data token held back", dt_ready, 0);
    @(negedge clk);
    ld_valid = 1'b0;
    #1;
    chk(dt_ready == 1, "R11", "data token taken next", dt_ready, 1);
    @(negedge clk);
    dt_valid = 1'b0;
    #1;
    chk(unmatched == 0, "R11", "new entry captured token", unmatched, 0);
    expect_token("R11", 8'h90, 8'hA0, 16'h4444, 16'h0005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_round_robin();
    t_wait_both();
    t_multicast();
    t_order();
    t_unmatched();
    t_full();
    t_clash();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule